// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block produces the timing enables for a UART: a one-cycle oversample pulse at sixteen times the bit rate, and a one-cycle bit pulse on every sixteenth oversample pulse. The core clock first passes through a power-of-two prescaler of 2^(CD+1) cycles. An optional fractional stage then divides by M + N/2048 on average. A divisor-latch counter of DL follows, and the result drives a divide-by-16 oversample counter. The UART shifters use the two pulses as clock enables.

With the fractional stage bypassed, one bit lasts 2^(CD+1) × 16 × DL core cycles. With the stage in the path, one bit lasts 2^(CD+1) × 16 × DL × (M + N/2048) cycles on long-term average. The fractional stage is a phase accumulator. Every period it adds N to an 11-bit phase and lasts M prescaler pulses, or M+1 pulses when that addition carries out. Standard rates can therefore be hit almost exactly. As an example, a 41.78 MHz clock with CD = 3, DL = 8, M = 1 and N = 128 gives 2176 cycles per bit, which is 19,200 baud. The plain path at the same setting is 6.25% off.

The divider settings are static inputs. When any of them differs from the value seen one cycle earlier, every counter and the phase restart from zero.

Top module: `frac_baud_gen`

## Requirements
- R1: With fracEn = 0, consecutive osTick pulses are exactly 2^(CD+1) × DL clock cycles apart. The first osTick follows the same spacing, counted from the restart edge.
- R2: bitTick is high only together with osTick. The n-th bitTick after a restart is the (16·n)-th osTick.
- R3: With fracEn = 1, let P = 2^(CD+1), K = 16·DL and f = floor(K·N/2048). Each bit period is either P·(K·M + f) or P·(K·M + f + 1) cycles.
- R4: With fracEn = 1, the b-th bitTick after a restart comes exactly P·(b·K·M + floor(b·K·N/2048)) clock edges after the restart edge. The long-term error is therefore zero.
- R5: A divisor latch of 0 behaves exactly like a divisor latch of 1, and the generator keeps producing pulses.
- R6: A fractional integer part M of 0 behaves exactly like M = 1.
- R7: A clock edge at which any divider input differs from its value at the previous edge is a restart edge. Every counter and the phase return to zero there. The first bitTick then comes exactly one full first-period count (R1/R4 with b = 1) of edges later, with no bitTick in between.
- R8: While rstN is low, osTick and bitTick are low. The first edge after rstN rises is a restart edge.
- R9: osTick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cdCode | input | 3 | Prescaler code CD; the prescaler divides by 2^(CD+1) |
| divLatch | input | 16 | Divisor latch DL (0 is taken as 1) |
| fracEn | input | 1 | 1 puts the M + N/2048 stage in the path |
| fracM | input | 4 | Integer part M of the fractional divisor (0 is taken as 1) |
| fracN | input | 11 | Numerator N over 2048 |
| osTick | output | 1 | One-cycle oversample enable, 16 per bit |
| bitTick | output | 1 | One-cycle bit enable, on every 16th osTick |

## Verification
One fractional setting runs for 2048 bit periods. Its tick times are compared edge by edge against the closed-form cumulative count. A design that let the phase drift, or that added the extra prescaler pulse in the wrong place, would pass a per-period test but fail this one. Divisor latch 0 and M = 0 are checked against the timing of value 1. A design that mishandled either would stall or produce a divide-by-65536 or divide-by-16 period. Every setting change is applied in the middle of a period, and the first tick must follow after exactly one clean period. A design that did not clear its counters and phase would emit a short or shifted first bit.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // restart all counters and the phase
    logic useFrac;  // route the fractional stage into the path
  } baud_strb_t;
endpackage

// File: rtl/frac_baud_ctrl.sv
module frac_baud_ctrl
  import frac_baud_pkg::*;
#(
  parameter int CD_W = 3,
  parameter int DL_W = 16,
  parameter int M_W  = 4,
  parameter int N_W  = 11
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CD_W-1:0] cdCode,
  input  logic [DL_W-1:0] divLatch,
  input  logic            fracEn,
  input  logic [M_W-1:0]  fracM,
  input  logic [N_W-1:0]  fracN,
  output baud_strb_t      strb,
  output logic [DL_W-1:0] dlEff,
  output logic [M_W-1:0]  mEff
);
  localparam int CFG_W = CD_W + DL_W + 1 + M_W + N_W;

  logic [CFG_W-1:0] cfgNow, cfgQ;
  logic             cfgValid;

  assign cfgNow = {cdCode, divLatch, fracEn, fracM, fracN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      cfgValid <= 1'b0;
    end else begin
      cfgQ     <= cfgNow;
      cfgValid <= 1'b1;
    end
  end

  // First edge after reset, or any changed setting, restarts the datapath
  assign strb.clear   = !cfgValid || (cfgNow != cfgQ);
  assign strb.useFrac = fracEn;

  // Zero divisors are taken as one
  assign dlEff = (divLatch == '0) ? DL_W'(1) : divLatch;
  assign mEff  = (fracM == '0) ? M_W'(1) : fracM;
endmodule

// File: rtl/frac_baud_dp.sv
module frac_baud_dp
  import frac_baud_pkg::*;
#(
  parameter int CD_W     = 3,
  parameter int DL_W     = 16,
  parameter int M_W      = 4,
  parameter int N_W      = 11,
  parameter int OS_RATIO = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  baud_strb_t      strb,
  input  logic [CD_W-1:0] cdCode,
  input  logic [DL_W-1:0] dlEff,
  input  logic [M_W-1:0]  mEff,
  input  logic [N_W-1:0]  fracN,
  output logic            osTick,
  output logic            bitTick
);
  localparam int PRE_W = (1 << CD_W) + 1;
  localparam int OS_W  = (OS_RATIO > 1) ? $clog2(OS_RATIO) : 1;

  logic [PRE_W-1:0] preCnt, preLast;
  logic [M_W:0]     fracCnt, target;
  logic [N_W-1:0]   phase;
  logic [N_W:0]     phaseSum;
  logic [DL_W-1:0]  dlCnt;
  logic [OS_W-1:0]  osCnt;
  logic             preTick, fracTick, stageTick, dlLast, osRaw, osLast;

  // Prescaler: 2^(CD+1) cycles per pulse
  assign preLast = (PRE_W'(1) << ({1'b0, cdCode} + 1'b1)) - PRE_W'(1);
  assign preTick = (preCnt == preLast);

  // Fractional stage: M or M+1 prescaler pulses, chosen by the phase carry
  assign phaseSum = {1'b0, phase} + {1'b0, fracN};
  assign target   = {1'b0, mEff} + {{M_W{1'b0}}, phaseSum[N_W]};
  assign fracTick = preTick && (fracCnt == target - 1'b1);

  assign stageTick = strb.useFrac ? fracTick : preTick;
  assign dlLast    = (dlCnt == dlEff - 1'b1);
  assign osRaw     = stageTick && dlLast;
  assign osLast    = (osCnt == OS_W'(OS_RATIO - 1));

  assign osTick  = osRaw && !strb.clear;
  assign bitTick = osTick && osLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      fracCnt <= '0;
      phase   <= '0;
      dlCnt   <= '0;
      osCnt   <= '0;
    end else if (strb.clear) begin
      preCnt  <= '0;
      fracCnt <= '0;
      phase   <= '0;
      dlCnt   <= '0;
      osCnt   <= '0;
    end else begin
      preCnt <= preTick ? '0 : preCnt + 1'b1;
      if (strb.useFrac && preTick) begin
        if (fracTick) begin
          fracCnt <= '0;
          phase   <= phaseSum[N_W-1:0];
        end else begin
          fracCnt <= fracCnt + 1'b1;
        end
      end
      if (stageTick) dlCnt <= dlLast ? '0 : dlCnt + 1'b1;
      if (osRaw)     osCnt <= osLast ? '0 : osCnt + 1'b1;
    end
  end

  // R7
  clear_quiets_os_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !osTick);

  // R9
  os_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    osTick |=> !osTick);

  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fracTick && !strb.clear) |=> $stable(phase));

  // R5
  dl_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |-> (dlCnt < dlEff));

  // R6
  frac_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |-> (fracCnt < target));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int CD_W     = 3,
  parameter int DL_W     = 16,
  parameter int M_W      = 4,
  parameter int N_W      = 11,
  parameter int OS_RATIO = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CD_W-1:0] cdCode,
  input  logic [DL_W-1:0] divLatch,
  input  logic            fracEn,
  input  logic [M_W-1:0]  fracM,
  input  logic [N_W-1:0]  fracN,
  output logic            osTick,
  output logic            bitTick
);
  baud_strb_t      strb;
  logic [DL_W-1:0] dlEff;
  logic [M_W-1:0]  mEff;

  frac_baud_ctrl #(.CD_W(CD_W), .DL_W(DL_W), .M_W(M_W), .N_W(N_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cdCode(cdCode), .divLatch(divLatch),
    .fracEn(fracEn), .fracM(fracM), .fracN(fracN),
    .strb(strb), .dlEff(dlEff), .mEff(mEff)
  );

  frac_baud_dp #(.CD_W(CD_W), .DL_W(DL_W), .M_W(M_W), .N_W(N_W),
                 .OS_RATIO(OS_RATIO)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .cdCode(cdCode), .dlEff(dlEff),
    .mEff(mEff), .fracN(fracN), .osTick(osTick), .bitTick(bitTick)
  );
endmodule

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cdCode = '0;
  logic [15:0] divLatch = '0;
  logic        fracEn = 1'b0;
  logic [3:0]  fracM = '0;
  logic [10:0] fracN = '0;
  logic        osTick, bitTick;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rstN(rstN), .cdCode(cdCode), .divLatch(divLatch),
    .fracEn(fracEn), .fracM(fracM), .fracN(fracN),
    .osTick(osTick), .bitTick(bitTick)
  );

  // cd, dl, en, m, n, bit periods
  localparam int NV = 8;
  localparam int VT [NV][6] = '{
    '{0, 1,  0, 1, 0,    20},
    '{1, 3,  0, 1, 0,    10},
    '{0, 1,  1, 1, 333,  2048},
    '{2, 1,  1, 2, 1000, 12},
    '{0, 0,  0, 1, 0,    10},
    '{0, 2,  1, 0, 512,  20},
    '{3, 8,  1, 1, 128,  8},
    '{3, 8,  1, 1, 700,  8}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic runVec(input int cd, input int dl, input int en, input int m,
                        input int n, input int nb, input string note);
    longint p, dle, me, kk, k, lastOs, lastBit, osCount, bits, expCum, lo, per;
    int perErr, cumErr, osErr, pairErr;
    longint firstK, firstExp, badAct, badExp;
    bit prevOs;
    p   = longint'(1) << (cd + 1);
    dle = (dl == 0) ? 1 : dl;
    me  = (m == 0) ? 1 : m;
    kk  = 16 * dle;
    lo  = en ? p * (kk * me + (kk * n) / 2048) : p * kk;
    perErr = 0; cumErr = 0; osErr = 0; pairErr = 0;
    firstK = -1; firstExp = 0; badAct = 0; badExp = 0;
    k = 0; lastOs = 0; lastBit = 0; osCount = 0; bits = 0; prevOs = 1'b0;
    repeat (37) @(negedge clk);
    cdCode = 3'(cd); divLatch = 16'(dl); fracEn = en[0];
    fracM = 4'(m); fracN = 11'(n);
    while (bits < nb && !finished) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (osTick && prevOs) pairErr++;
      prevOs = osTick;
      if (osTick) begin
        osCount++;
        if (!en && (k - lastOs) != p * dle) osErr++;
        lastOs = k;
      end
      if (bitTick) begin
        bits++;
        if (!osTick || osCount != 16 * bits) osErr++;
        expCum = en ? p * (bits * kk * me + (bits * kk * n) / 2048) : p * bits * kk;
        if (k != expCum) begin
          if (cumErr == 0) begin badAct = k; badExp = expCum; end
          cumErr++;
        end
        per = k - lastBit;
        if (!(per == lo || (en && per == lo + p))) perErr++;
        if (bits == 1) begin firstK = k; firstExp = expCum; end
        lastBit = k;
      end
    end
    // R7: first bit after a mid-period change is one clean period
    check(firstK == firstExp, "R7", {note, " first tick edge"}, firstK, firstExp);
    // R1 / R3: per-period spacing
    check(perErr == 0, en ? "R3" : "R1", {note, " bad periods"}, perErr, 0);
    // R4: exact cumulative timing (plain path also checked here)
    check(cumErr == 0, en ? "R4" : "R1", {note, " cumulative edge"}, badAct, badExp);
    // R2: 16 oversample pulses per bit, coincident
    check(osErr == 0, "R2", {note, " oversample relation"}, osErr, 0);
    // R9
    check(pairErr == 0, "R9", {note, " back-to-back osTick"}, pairErr, 0);
  endtask

  initial begin
    longint k;
    int hiSeen;
    // R8: reset holds outputs low
    cdCode = 3'd1; divLatch = 16'd1; fracEn = 1'b0; fracM = 4'd1; fracN = '0;
    hiSeen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (osTick || bitTick) hiSeen++;
    end
    check(hiSeen == 0, "R8", "outputs during reset", hiSeen, 0);
    rstN = 1'b1;
    k = 0;
    while (k < 200) begin
      @(posedge clk);
      @(negedge clk);
      k++;
      if (bitTick) break;
    end
    // R8: P=4, K=16 gives 64 edges to the first bit
    check(k == 64, "R8", "first bit after reset", k, 64);

    for (int v = 0; v < NV; v++) begin
      string note;
      note = (v == 4) ? "R5 dl0" : (v == 5) ? "R6 m0" : $sformatf("vec%0d", v);
      runVec(VT[v][0], VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], note);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule